// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Reader

This block models a sequential-read memory that streams a stored configuration bitstream into a loader. An internal address counter walks the stored bytes. In serial mode the reader sends one bit per clock. In byte-wide mode it sends one byte per clock. Each data bit has its own enable line, which stands in for a tri-state pad. A chain enable output lets several readers form one stream. When a reader moves past its last word, it releases the shared bus and pulls its chain output low. That output drives the chip enable of the next reader.

The loader controls the reader with three inputs. The active-low chip enable selects the device. A combined output-enable/reset pin has a polarity that is set by an option bit. A hold input freezes the stream while the loader is not ready. A second option bit selects serial or byte-wide output. Both option bits are taken to be static while a stream is being read. The stored contents are loaded through a plain synchronous write port, and only the testbench uses it.

Top module: `cfg_prom_reader`

## Requirements
- R1: At a rising clock edge the position counter advances by one only when `ce_n` is 0, the output-enable function is active, `hold` is 0 and the counter has not passed terminal count. In every other case it keeps its value or is cleared.
- R2: `opt_rst_low`=0 means `oe_rst`=1 is reset. `opt_rst_low`=1 means `oe_rst`=0 is reset. While reset is active, `dq_oe` is 0 and `chain_ce_n` is 1, and the first rising edge during reset returns the counter to the first position. This happens even when `hold` is 1.
- R3: While `ce_n` is 1, `dq_oe` is 0 and `chain_ce_n` is 1 whatever the state of `oe_rst`. Each rising edge in this state clears the counter to the first position.
- R4: `dq_oe` is nonzero only when `ce_n` is 0, the output-enable function is active and the counter has not passed terminal count. Any bit whose `dq_oe` bit is 0 is driven 0 on `dq`.
- R5: A rising edge with `hold`=1 leaves the position unchanged, so `dq` and `dq_oe` keep their values.
- R6: Terminal count is the last position: DEPTH*8-1 in serial mode and DEPTH-1 in byte-wide mode. The counter stops one step past terminal count and never wraps to the start.
- R7: `chain_ce_n` is 0 exactly when `ce_n` is 0, the output-enable function is active and the counter has passed terminal count. It returns to 1 in the same cycle that either condition goes away. While it is 0, `dq_oe` is 0.
- R8: Serial mode (`opt_byte_wide`=0) drives only bit 0, with `dq_oe`=8'h01. Position p shows bit 7-(p mod 8) of byte p/8, so each byte goes out most significant bit first.
- R9: Byte-wide mode (`opt_byte_wide`=1) drives all eight bits with `dq_oe`=8'hFF. Position p shows byte p.
- R10: Outputs depend only on the current position. After reset is released, the word at position 0 appears without a clock edge, and each advancing edge shows the next word before the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock from the loader |
| ce_n | input | 1 | Chip enable, active low |
| oe_rst | input | 1 | Combined output-enable / counter reset pin |
| opt_rst_low | input | 1 | Option: 1 makes a low `oe_rst` the reset level |
| opt_byte_wide | input | 1 | Option: 1 selects byte-wide output, 0 serial |
| hold | input | 1 | Freezes the counter when high at a clock edge |
| wr_en | input | 1 | Contents write strobe |
| wr_addr | input | AW | Contents write byte address |
| wr_data | input | 8 | Contents write byte |
| dq | output | 8 | Read data, 0 on disabled bits |
| dq_oe | output | 8 | Per-bit drive enable |
| chain_ce_n | output | 1 | Chip enable for the next reader in the chain |

## Verification
Hold and counter clearing can both be requested at the same clock edge. Hold can also be high on the edge that would carry the counter past terminal count. The bench provokes the first overlap directly by asserting reset while `hold` is high, and judges it by expecting position 0 after the edge (clear wins). Random phases mix hold, reset and chip-enable toggles, including around the handoff edge. A reference position kept in the bench from the requirement rules predicts `dq`, `dq_oe` and `chain_ce_n` in every cycle.

// File: rtl/cfg_prom_reader.sv
module cfg_prom_reader #(
  parameter int DEPTH = 16,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          oe_rst,
  input  logic          opt_rst_low,
  input  logic          opt_byte_wide,
  input  logic          hold,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    dq,
  output logic [7:0]    dq_oe,
  output logic          chain_ce_n
);
  localparam int CW = $clog2(DEPTH*8) + 1;
  localparam logic [CW-1:0] TC_BIT  = CW'(DEPTH*8 - 1);
  localparam logic [CW-1:0] TC_BYTE = CW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt, tc;
  logic [AW-1:0] baddr;
  logic [7:0]    word;
  logic          rst_act, clear, past, live, step, sbit;

  assign rst_act = opt_rst_low ? ~oe_rst : oe_rst;
  assign clear   = ce_n | rst_act;
  assign tc      = opt_byte_wide ? TC_BYTE : TC_BIT;
  assign past    = cnt > tc;
  assign live    = ~clear & ~past;
  assign step    = live & ~hold;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk)
    if (clear)     cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;

  assign baddr = opt_byte_wide ? cnt[AW-1:0] : cnt[AW+2:3];
  assign word  = mem[baddr];
  assign sbit  = word[~cnt[2:0]];

  assign dq_oe      = !live ? 8'h00 : (opt_byte_wide ? 8'hFF : 8'h01);
  assign dq         = dq_oe & (opt_byte_wide ? word : {7'b0, sbit});
  assign chain_ce_n = ~(~clear & past);
endmodule

module cfg_prom_reader_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          ce_n,
  input logic          clear,
  input logic          hold,
  input logic          byte_mode,
  input logic          past,
  input logic [CW-1:0] cnt,
  input logic [7:0]    dq_oe,
  input logic          chain_ce_n
);
  always_comb begin
    AST_STANDBY_FLOAT: assert (!ce_n || dq_oe == 8'h00); // R3
    AST_HANDOFF_EXCL: assert (chain_ce_n || dq_oe == 8'h00); // R7
    AST_SERIAL_LANE: assert (byte_mode || dq_oe[7:1] == 7'b0); // R8
  end

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (clear)
    hold |=> $stable(cnt)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (clear)
    past |=> past); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (clear)
    (!hold && !past) |=> cnt == $past(cnt) + 1'b1); // R1
endmodule

bind cfg_prom_reader cfg_prom_reader_chk #(.CW(CW)) u_chk (
  .clk(clk), .ce_n(ce_n), .clear(clear), .hold(hold), .byte_mode(opt_byte_wide),
  .past(past), .cnt(cnt), .dq_oe(dq_oe), .chain_ce_n(chain_ce_n)
);

// File: tb/tb_cfg_prom_reader.sv
module tb_cfg_prom_reader;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic ce_n = 1'b1, oe_rst = 1'b0, opt_rst_low = 1'b0, opt_byte_wide = 1'b0, hold = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] dq, dq_oe;
  logic chain_ce_n;

  logic [7:0] img [DEPTH];
  int pos = 0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cfg_prom_reader #(.DEPTH(DEPTH)) dut (
    .clk(clk), .ce_n(ce_n), .oe_rst(oe_rst), .opt_rst_low(opt_rst_low),
    .opt_byte_wide(opt_byte_wide), .hold(hold), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dq(dq), .dq_oe(dq_oe), .chain_ce_n(chain_ce_n)
  );

  function automatic bit rst_on();
    return opt_rst_low ? !oe_rst : oe_rst;
  endfunction
  function automatic int term();
    return opt_byte_wide ? DEPTH - 1 : DEPTH*8 - 1;
  endfunction
  function automatic bit en_exp();
    return !ce_n && !rst_on() && pos <= term();
  endfunction
  function automatic logic [7:0] oe_exp();
    return !en_exp() ? 8'h00 : (opt_byte_wide ? 8'hFF : 8'h01);
  endfunction
  function automatic logic [7:0] dq_exp();
    if (!en_exp()) return 8'h00;
    if (opt_byte_wide) return img[pos];
    return {7'b0, img[pos/8][7 - pos%8]};
  endfunction
  function automatic logic chain_exp();
    return !(!ce_n && !rst_on() && pos > term());
  endfunction

  task automatic check(input string tag);
    string t = tag;
    if (t == "") begin
      if (ce_n) t = "R3";
      else if (rst_on()) t = "R2";
      else if (pos > term()) t = "R7";
      else if (hold) t = "R5";
      else t = opt_byte_wide ? "R9" : "R8";
    end
    n_chk++;
    if (dq !== dq_exp() || dq_oe !== oe_exp() || chain_ce_n !== chain_exp()) begin
      n_bad++;
      $display("FAIL %s pos=%0d dq=%h/%h oe=%h/%h chain=%b/%b (actual/expected)",
               t, pos, dq, dq_exp(), dq_oe, oe_exp(), chain_ce_n, chain_exp());
    end
  endtask

  task automatic cyc(input string tag);
    #1 check(tag);
    @(posedge clk);
    if (ce_n || rst_on()) pos = 0;
    else if (!hold && pos <= term()) pos++;
    @(negedge clk);
  endtask

  task automatic oe_on(input bit on);
    oe_rst = opt_rst_low ? on : !on;
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      img[i] = 8'($urandom);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = img[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
    cyc("R3");
    // serial full read, active-high reset polarity
    opt_rst_low = 1'b0; oe_on(1'b1); ce_n = 1'b0;
    cyc("R10");
    for (int i = 1; i < DEPTH*8; i++) cyc("R8");
    for (int i = 0; i < 4; i++) cyc("R6");
    cyc("R7");
    oe_on(1'b0);
    cyc("R2");
    oe_on(1'b1);
    cyc("R10");
    // byte-wide mode, active-low reset polarity
    ce_n = 1'b1; opt_byte_wide = 1'b1; opt_rst_low = 1'b1; oe_on(1'b1);
    cyc("R3");
    ce_n = 1'b0;
    for (int i = 0; i < 5; i++) cyc("R9");
    hold = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R5");
    oe_on(1'b0);
    cyc("R2");
    cyc("R4");
    oe_on(1'b1);
    cyc("R1");
    hold = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) cyc("R1");
    cyc("R6");
    ce_n = 1'b1;
    cyc("R7");
    // random segments
    for (int s = 0; s < 8; s++) begin
      ce_n = 1'b1; opt_byte_wide = 1'($urandom); opt_rst_low = 1'($urandom);
      cyc("");
      for (int i = 0; i < 400; i++) begin
        ce_n = ($urandom % 40) == 0;
        oe_on(($urandom % 50) != 0);
        hold = ($urandom % 4) == 0;
        cyc("");
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule